// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller Core

This core collects interrupt requests on eight lines, keeps them in a pending register, and decides which one the processor is handed when it acknowledges. A mask register hides chosen lines from the decision. An in-service register records the levels whose handlers are running. A pending request is raised to the processor only when it outranks everything already in service, so handlers nest strictly by priority.

Priority is circular. One level is held as the current bottom of the order, and the level just above it, modulo eight, is the top. Reset makes level 7 the bottom, so level 0 is the top. A 3-bit command made of a rotate flag, a select flag and an end-of-service flag, together with a 3-bit level, ends a service period. The same command can also move the bottom of the order or switch rotation in automatic-end mode. When the automatic-end input is high, an acknowledge never leaves an in-service bit behind. If rotation is on in that mode, the granted level becomes the new bottom.

Top module: `prio_irq_core`

## Requirements
- R1: After reset the pending, in-service and mask registers read 0, the lowest-priority level reads 7, the vector reads 0 and the interrupt line is low.
- R2: A high request line n sets pending bit n at the next clock edge. The bit stays set until level n is granted, and the grant clears it.
- R3: On maskWr the mask register loads maskIn. A pending level whose mask bit is 1 never raises the interrupt line and is never granted.
- R4: The rank of level n is (n - lowest - 1) mod 8, and rank 0 is served first. The interrupt line is high exactly when the best-ranked unmasked pending level ranks above every in-service level, or when that level exists and nothing is in service.
- R5: An acknowledge while the interrupt line is high grants that best level. The vector takes the level, the pending bit clears, and the in-service bit sets unless the automatic-end input is high. An acknowledge while the line is low changes nothing.
- R6: Command code {rotate,select,end} = 001 clears the best-ranked in-service bit.
- R7: Code 011 clears the in-service bit of the given level.
- R8: Code 101 clears the best-ranked in-service bit and makes that level the lowest; with nothing in service it does nothing. Code 111 clears the in-service bit of the given level and makes that level the lowest.
- R9: Code 110 makes the given level the lowest without touching any other register. Code 010 has no effect.
- R10: Code 100 turns on rotation in automatic-end mode and code 000 turns it off. While the automatic-end input is high and rotation is on, a grant makes the granted level the lowest.
- R11: When an acknowledge and a command arrive in the same cycle, both act on the state before that edge. If both change the lowest level, the command's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 8 | Request lines, one per level |
| ackPulse | input | 1 | One-cycle acknowledge from the processor |
| autoEoi | input | 1 | High selects automatic end of service |
| cmdValid | input | 1 | Command strobe |
| cmdRot | input | 1 | Command rotate flag |
| cmdSel | input | 1 | Command select (use level) flag |
| cmdEoi | input | 1 | Command end-of-service flag |
| cmdLevel | input | 3 | Command level, binary 0 to 7 |
| maskWr | input | 1 | Mask register load strobe |
| maskIn | input | 8 | New mask value, 1 hides a level |
| irrOut | output | 8 | Pending request register |
| isrOut | output | 8 | In-service register |
| imrOut | output | 8 | Mask register |
| lowPrio | output | 3 | Current lowest-priority level |
| vecLevel | output | 3 | Level of the most recent grant |
| intOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions take for granted that acknowledge and command strobes each last one cycle and are sampled on the rising edge. Several properties also assume that no command or mask write shares a cycle with the event they describe, so each carries that condition in its antecedent. The directed stimulus gives acknowledges only when the interrupt line is expected high. The random stimulus covers the remaining cases: acknowledges on a low line, coincident commands, and changes to the automatic-end input at any time. A behavioural model follows every one of these cases.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned LEVELS = 8;
  localparam int unsigned LVL_W  = $clog2(LEVELS);

  typedef logic [LEVELS-1:0] lvlVec_t;
  typedef logic [LVL_W-1:0]  lvlIdx_t;

  // {rotate, select, end-of-service}
  typedef enum logic [2:0] {
    CMD_AEOI_ROT_OFF = 3'b000,
    CMD_NS_EOI       = 3'b001,
    CMD_NOP          = 3'b010,
    CMD_S_EOI        = 3'b011,
    CMD_AEOI_ROT_ON  = 3'b100,
    CMD_ROT_NS_EOI   = 3'b101,
    CMD_SET_PRIO     = 3'b110,
    CMD_ROT_S_EOI    = 3'b111
  } cmdCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    grant;
    logic    setIsr;
    logic    clrHighest;
    logic    clrSpecific;
    lvlIdx_t clrLevel;
  } dpStrobe_t;

  function automatic lvlVec_t oneHot(lvlIdx_t idx);
    return lvlVec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/prio_irq_resolver.sv
// Finds the best-ranked set bit of a vector under a circular priority order
module prio_irq_resolver
  import prio_irq_pkg::*;
(
  input  lvlVec_t vecIn,
  input  lvlIdx_t lowest,
  output logic    found,
  output lvlIdx_t rank,
  output lvlIdx_t level
);
  lvlIdx_t startIdx;
  lvlVec_t rotated;

  assign startIdx = lowest + lvlIdx_t'(1);

  generate
    for (genvar k = 0; k < LEVELS; k++) begin : g_rot
      lvlIdx_t srcIdx;
      assign srcIdx     = startIdx + lvlIdx_t'(k);
      assign rotated[k] = vecIn[srcIdx];
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int k = LEVELS - 1; k >= 0; k--) begin
      if (rotated[k]) begin
        found = 1'b1;
        rank  = lvlIdx_t'(k);
      end
    end
  end

  assign level = startIdx + rank;
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  lvlVec_t   irqReq,
  input  logic      maskWr,
  input  lvlVec_t   maskIn,
  input  lvlIdx_t   lowest,
  input  dpStrobe_t strobe,
  output lvlVec_t   irrQ,
  output lvlVec_t   isrQ,
  output lvlVec_t   imrQ,
  output lvlIdx_t   vecQ,
  output logic      intReq,
  output lvlIdx_t   winLevel,
  output logic      highIsrFound,
  output lvlIdx_t   highIsrLevel
);
  lvlVec_t pending;
  logic    reqFound;
  lvlIdx_t reqRank;
  lvlIdx_t isrRank;
  lvlVec_t grantMask;
  lvlVec_t setMask;
  lvlVec_t clrMask;

  assign pending = irrQ & ~imrQ;

  prio_irq_resolver u_reqRes (
    .vecIn (pending),
    .lowest(lowest),
    .found (reqFound),
    .rank  (reqRank),
    .level (winLevel)
  );

  prio_irq_resolver u_isrRes (
    .vecIn (isrQ),
    .lowest(lowest),
    .found (highIsrFound),
    .rank  (isrRank),
    .level (highIsrLevel)
  );

  assign intReq = reqFound && (!highIsrFound || (reqRank < isrRank));

  always_comb begin
    grantMask = strobe.grant ? oneHot(winLevel) : '0;
    setMask   = strobe.setIsr ? grantMask : '0;
    clrMask   = '0;
    if (strobe.clrHighest && highIsrFound) clrMask = clrMask | oneHot(highIsrLevel);
    if (strobe.clrSpecific)                clrMask = clrMask | oneHot(strobe.clrLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ <= '0;
      isrQ <= '0;
      imrQ <= '0;
      vecQ <= '0;
    end else begin
      irrQ <= (irrQ | irqReq) & ~grantMask;
      isrQ <= (isrQ & ~clrMask) | setMask;
      if (maskWr)       imrQ <= maskIn;
      if (strobe.grant) vecQ <= winLevel;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ackPulse,
  input  logic      autoEoi,
  input  logic      cmdValid,
  input  cmdCode_t  cmdCode,
  input  lvlIdx_t   cmdLevel,
  input  logic      intReq,
  input  lvlIdx_t   winLevel,
  input  logic      highIsrFound,
  input  lvlIdx_t   highIsrLevel,
  output dpStrobe_t strobe,
  output lvlIdx_t   lowest
);
  logic    rotAeoi;
  logic    rotAeoiNext;
  lvlIdx_t lowestNext;

  always_comb begin
    strobe.grant       = ackPulse && intReq;
    strobe.setIsr      = ackPulse && intReq && !autoEoi;
    strobe.clrHighest  = cmdValid && (cmdCode == CMD_NS_EOI || cmdCode == CMD_ROT_NS_EOI);
    strobe.clrSpecific = cmdValid && (cmdCode == CMD_S_EOI || cmdCode == CMD_ROT_S_EOI);
    strobe.clrLevel    = cmdLevel;
  end

  always_comb begin
    lowestNext  = lowest;
    rotAeoiNext = rotAeoi;
    if (ackPulse && intReq && autoEoi && rotAeoi) lowestNext = winLevel;
    if (cmdValid) begin
      unique case (cmdCode)
        CMD_ROT_NS_EOI:   if (highIsrFound) lowestNext = highIsrLevel;
        CMD_ROT_S_EOI,
        CMD_SET_PRIO:     lowestNext = cmdLevel;
        CMD_AEOI_ROT_ON:  rotAeoiNext = 1'b1;
        CMD_AEOI_ROT_OFF: rotAeoiNext = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowest  <= lvlIdx_t'(LEVELS - 1);
      rotAeoi <= 1'b0;
    end else begin
      lowest  <= lowestNext;
      rotAeoi <= rotAeoiNext;
    end
  end
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqReq,
  input  logic       ackPulse,
  input  logic       autoEoi,
  input  logic       cmdValid,
  input  logic       cmdRot,
  input  logic       cmdSel,
  input  logic       cmdEoi,
  input  logic [2:0] cmdLevel,
  input  logic       maskWr,
  input  logic [7:0] maskIn,
  output logic [7:0] irrOut,
  output logic [7:0] isrOut,
  output logic [7:0] imrOut,
  output logic [2:0] lowPrio,
  output logic [2:0] vecLevel,
  output logic       intOut
);
  dpStrobe_t strobe;
  lvlIdx_t   lowest;
  logic      intReq;
  lvlIdx_t   winLevel;
  logic      highIsrFound;
  lvlIdx_t   highIsrLevel;
  cmdCode_t  cmdCode;

  assign cmdCode = cmdCode_t'({cmdRot, cmdSel, cmdEoi});

  prio_irq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ackPulse    (ackPulse),
    .autoEoi     (autoEoi),
    .cmdValid    (cmdValid),
    .cmdCode     (cmdCode),
    .cmdLevel    (cmdLevel),
    .intReq      (intReq),
    .winLevel    (winLevel),
    .highIsrFound(highIsrFound),
    .highIsrLevel(highIsrLevel),
    .strobe      (strobe),
    .lowest      (lowest)
  );

  prio_irq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .irqReq      (irqReq),
    .maskWr      (maskWr),
    .maskIn      (maskIn),
    .lowest      (lowest),
    .strobe      (strobe),
    .irrQ        (irrOut),
    .isrQ        (isrOut),
    .imrQ        (imrOut),
    .vecQ        (vecLevel),
    .intReq      (intReq),
    .winLevel    (winLevel),
    .highIsrFound(highIsrFound),
    .highIsrLevel(highIsrLevel)
  );

  assign lowPrio = lowest;
  assign intOut  = intReq;
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ackPulse,
  input logic       autoEoi,
  input logic       cmdValid,
  input logic       cmdRot,
  input logic       cmdSel,
  input logic       cmdEoi,
  input logic [2:0] cmdLevel,
  input logic       maskWr,
  input logic [7:0] irrOut,
  input logic [7:0] isrOut,
  input logic [7:0] imrOut,
  input logic [2:0] lowPrio,
  input logic [2:0] vecLevel,
  input logic       intOut
);
  logic [2:0] cmd;
  assign cmd = {cmdRot, cmdSel, cmdEoi};

  AST_INT_HAS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irrOut & ~imrOut) != 8'd0)); // R4

  AST_GRANT_NOT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && intOut) |=> (($past(imrOut) & (8'd1 << vecLevel)) == 8'd0)); // R3

  AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && intOut && !autoEoi && !cmdValid) |=>
      ($countones(isrOut) == $countones($past(isrOut)) + 1)); // R5

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && !intOut && !cmdValid) |=> ($stable(isrOut) && $stable(vecLevel))); // R5

  AST_SPEC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmd == 3'b011 && !ackPulse) |=>
      ((isrOut & (8'd1 << $past(cmdLevel))) == 8'd0)); // R7

  AST_SET_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmd == 3'b110) |=> (lowPrio == $past(cmdLevel))); // R9

  AST_NOP_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmd == 3'b010 && !ackPulse && !maskWr) |=>
      ($stable(isrOut) && $stable(lowPrio) && $stable(imrOut))); // R9

  AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (autoEoi && !cmdValid) |=> ((isrOut & ~$past(isrOut)) == 8'd0)); // R10
endmodule

bind prio_irq_core prio_irq_checker u_chk (.*);

// File: tb/tb_prio_irq_core.sv
`timescale 1ns/1ps
module tb_prio_irq_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqReq = '0;
  logic       ackPulse = 1'b0;
  logic       autoEoi = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdRot = 1'b0;
  logic       cmdSel = 1'b0;
  logic       cmdEoi = 1'b0;
  logic [2:0] cmdLevel = '0;
  logic       maskWr = 1'b0;
  logic [7:0] maskIn = '0;
  logic [7:0] irrOut, isrOut, imrOut;
  logic [2:0] lowPrio, vecLevel;
  logic       intOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prio_irq_core dut (.*);

  // Behavioural reference model
  bit [7:0] mIrr, mIsr, mImr;
  int mLow, mVec;
  bit mRotA;

  function automatic int rankOf(int n, int low);
    return (n - low - 1 + 16) % 8;
  endfunction

  function automatic int best(bit [7:0] v, int low);
    int b = -1;
    for (int n = 0; n < 8; n++)
      if (v[n] && (b < 0 || rankOf(n, low) < rankOf(b, low))) b = n;
    return b;
  endfunction

  function automatic bit modelInt();
    int w = best(mIrr & ~mImr, mLow);
    int h = best(mIsr, mLow);
    return (w >= 0) && (h < 0 || rankOf(w, mLow) < rankOf(h, mLow));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIrr = 0; mIsr = 0; mImr = 0; mLow = 7; mVec = 0; mRotA = 0;
    end else begin
      int w, h, newLow;
      bit g;
      bit [7:0] nIrr, nIsr;
      bit [2:0] c;
      w = best(mIrr & ~mImr, mLow);
      h = best(mIsr, mLow);
      g = ackPulse && modelInt();
      c = {cmdRot, cmdSel, cmdEoi};
      nIrr = mIrr | irqReq;
      nIsr = mIsr;
      newLow = mLow;
      if (g) begin
        nIrr[w] = 1'b0;
        if (!autoEoi) nIsr[w] = 1'b1;
        else if (mRotA) newLow = w;
      end
      if (cmdValid) begin
        case (c)
          3'b001: if (h >= 0) nIsr[h] = 1'b0;
          3'b011: nIsr[cmdLevel] = 1'b0;
          3'b101: if (h >= 0) begin nIsr[h] = 1'b0; newLow = h; end
          3'b111: begin nIsr[cmdLevel] = 1'b0; newLow = cmdLevel; end
          3'b110: newLow = cmdLevel;
          3'b100: mRotA = 1;
          3'b000: mRotA = 0;
          default: ;
        endcase
      end
      if (maskWr) mImr = maskIn;
      if (g) mVec = w;
      mIrr = nIrr; mIsr = nIsr; mLow = newLow;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 irr", irrOut, mIrr);
      chk("R5 isr", isrOut, mIsr);
      chk("R3 imr", imrOut, mImr);
      chk("R8 lowPrio", lowPrio, mLow);
      chk("R5 vecLevel", vecLevel, mVec);
      chk("R4 intOut", intOut, modelInt());
    end
  end

  task automatic idle();
    irqReq = '0; ackPulse = 0; cmdValid = 0; maskWr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic setCmd(bit [2:0] c, int lvl);
    cmdValid = 1; {cmdRot, cmdSel, cmdEoi} = c; cmdLevel = 3'(lvl);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finished = 1;
    report();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irr", irrOut, 0); chk("R1 isr", isrOut, 0); chk("R1 imr", imrOut, 0);
    chk("R1 lowPrio", lowPrio, 7); chk("R1 vec", vecLevel, 0); chk("R1 int", intOut, 0);

    irqReq = 8'h24; step();
    chk("R2 irr", irrOut, 8'h24); chk("R4 int", intOut, 1);
    ackPulse = 1; step();
    chk("R5 vec", vecLevel, 2); chk("R5 isr", isrOut, 8'h04);
    chk("R5 irr", irrOut, 8'h20); chk("R4 int", intOut, 0);
    setCmd(3'b001, 0); step();
    chk("R6 isr", isrOut, 0); chk("R6 int", intOut, 1);
    ackPulse = 1; step();
    chk("R5 vec", vecLevel, 5); chk("R5 isr", isrOut, 8'h20);
    setCmd(3'b011, 5); step();
    chk("R7 isr", isrOut, 0);
    setCmd(3'b110, 4); step();
    chk("R9 lowPrio", lowPrio, 4);
    setCmd(3'b010, 1); step();
    chk("R9 nop lowPrio", lowPrio, 4); chk("R9 nop isr", isrOut, 0);

    maskWr = 1; maskIn = 8'h01; step();
    irqReq = 8'h03; step();
    chk("R3 imr", imrOut, 8'h01); chk("R3 int", intOut, 1);
    ackPulse = 1; step();
    chk("R3 vec", vecLevel, 1); chk("R3 isr", isrOut, 8'h02); chk("R3 irr", irrOut, 8'h01);
    setCmd(3'b101, 0); step();
    chk("R8 isr", isrOut, 0); chk("R8 lowPrio", lowPrio, 1);
    setCmd(3'b111, 3); step();
    chk("R8 spec lowPrio", lowPrio, 3);

    maskWr = 1; maskIn = 8'h00; autoEoi = 1; setCmd(3'b100, 0); irqReq = 8'h40; step();
    chk("R2 irr", irrOut, 8'h41);
    ackPulse = 1; step();
    chk("R10 vec", vecLevel, 6); chk("R10 isr", isrOut, 0); chk("R10 lowPrio", lowPrio, 6);
    setCmd(3'b000, 0); step();
    ackPulse = 1; step();
    chk("R10 vec", vecLevel, 0); chk("R10 lowPrio", lowPrio, 6); chk("R10 isr", isrOut, 0);

    setCmd(3'b100, 0); irqReq = 8'h08; step();
    ackPulse = 1; setCmd(3'b110, 0); step();
    chk("R11 lowPrio", lowPrio, 0); chk("R11 vec", vecLevel, 3);
    autoEoi = 0;

    // Random phase, checked against the model every cycle
    for (int i = 0; i < 2000; i++) begin
      irqReq   = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      ackPulse = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0) setCmd(3'($urandom), $urandom_range(0, 7));
      if ($urandom_range(0, 19) == 0) begin maskWr = 1; maskIn = 8'($urandom) & 8'($urandom); end
      if ($urandom_range(0, 29) == 0) autoEoi = ~autoEoi;
      step();
    end
    finished = 1;
    report();
  end
endmodule